// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the software-visible control side of one channel of a disk-style bus-master DMA function. It holds a command register, a status register and a 32-bit pointer to the descriptor table in memory. From register writes it works out when a descriptor engine should start or abandon a transfer. It keeps the engine's current-descriptor pointer, and it records interrupt and error events from the drive and the engine. Descriptor fetching and data movement belong to the engine and are not part of this block.

Software writes the table pointer first. It then sets the start bit to launch a transfer, and later clears the start bit to stop. Only a change of the start bit has an effect; rewriting the same value is harmless. The drive's interrupt line is passed straight to the interrupt output, and each rising edge is also latched into a status bit. Software clears that bit by writing a one to it.

The register port is dword-wide with byte enables. Dword 0 (`reg_sel`=0) holds the command register in byte 0 and the status register in byte 2. Dword 1 (`reg_sel`=1) holds the table pointer, little-endian.

Top module: `busmaster_dma_regs`

## Requirements
- R1: While reset is low, `eng_cancel` is 1. Command, status, table pointer and current-descriptor pointer all read as zero.
- R2: The command register keeps only bit 0 (start) and bit 3 (direction). Every other bit reads back as 0. Command is in bits 7:0 of dword 0.
- R3: A command write with byte enable 0 set that leaves the start bit unchanged produces no start or cancel pulse and leaves the active bit unchanged.
- R4: When a command write changes start from 0 to 1, the current-descriptor pointer loads the table pointer. If active (status bit 0) was clear, active is set and `eng_start` is high for exactly one cycle, the cycle after the write.
- R5: When a command write changes start from 1 to 0, active is cleared and `eng_cancel` is high for exactly one cycle, the cycle after the write.
- R6: Each byte of the table pointer is written only when its byte enable is set. Bits 1:0 always read 0.
- R7: `irq_out` always equals `drv_irq`. A rising edge of `drv_irq` sets the interrupt bit (status bit 2). A falling edge does not clear it.
- R8: Status is in bits 23:16 of dword 0. Writing 1 to status bit 1 (error) or bit 2 (interrupt) clears that bit. Active cannot be written. A set event in the same cycle wins over the clear.
- R9: When `eng_done` is pulsed, active takes the value of `eng_more`. A start-bit change in the same cycle overrides this.
- R10: An `eng_next` pulse advances the current-descriptor pointer by 8 bytes. An `eng_err` pulse sets the error bit.
- R11: `eng_dir` equals command bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Dword select: 0 for command/status, 1 for table pointer |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected dword |
| drv_irq | input | 1 | Interrupt level from the drive |
| irq_out | output | 1 | Interrupt level to the host |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_cancel | output | 1 | Cancel request to the engine |
| eng_done | input | 1 | Engine ends its current transfer |
| eng_more | input | 1 | Qualifies `eng_done`: keep active set |
| eng_next | input | 1 | Engine moves to the next descriptor |
| eng_err | input | 1 | Engine reports an error |
| eng_dir | output | 1 | Transfer direction from the command register |
| cur_desc_ptr | output | 32 | Current descriptor address |

## Verification
On every cycle the assertions check the following:
- start pulses last one cycle and come only with active set;
- a cancel never coincides with active or with a start;
- reserved command bits stay zero;
- a same-value start write stays quiet;
- a reload takes the old table pointer;
- latched interrupt and error events appear on the next cycle.

Only the bench's scenarios can show other behaviour. This includes byte-lane merging of the pointer, the case where start rises while the channel is still active, the ordering between an engine end and a start-bit change, and the value read back through the register port after each write.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
  localparam int ST_ACT_BIT = 0;
  localparam int ST_ERR_BIT = 1;
  localparam int ST_INT_BIT = 2;
  localparam int CMD_BYTE  = 0;
  localparam int STAT_BYTE = 2;

  typedef struct packed {
    logic irq;
    logic err;
    logic act;
  } stat_t;

  function automatic logic [7:0] cmd_keep(input logic [7:0] v);
    return v & CMD_KEEP_MASK;
  endfunction

  function automatic logic [7:0] stat_byte(input stat_t s);
    return {5'b0, s};
  endfunction
endpackage

// File: rtl/bmr_cmd_ctrl.sv
module bmr_cmd_ctrl
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wbyte,
  input  logic       eng_done,
  input  logic       eng_more,
  output logic [7:0] cmd_q,
  output logic       active_q,
  output logic       start_q,
  output logic       cancel_q,
  output logic       reload
);
  logic start_rise, start_fall, act_nx;

  always_comb begin
    start_rise = cmd_we &  cmd_wbyte[CMD_START_BIT] & ~cmd_q[CMD_START_BIT];
    start_fall = cmd_we & ~cmd_wbyte[CMD_START_BIT] &  cmd_q[CMD_START_BIT];
    reload     = start_rise;
    act_nx     = active_q;
    if (eng_done)   act_nx = eng_more;
    if (start_rise && !active_q) act_nx = 1'b1;
    if (start_fall) act_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      active_q <= 1'b0;
      start_q  <= 1'b0;
      cancel_q <= 1'b1;
    end else begin
      if (cmd_we) cmd_q <= cmd_keep(cmd_wbyte);
      active_q <= act_nx;
      start_q  <= start_rise & ~active_q;
      cancel_q <= start_fall;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R4
  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> active_q); // R4
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q |-> (!active_q && !start_q)); // R5
  AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~CMD_KEEP_MASK) == 8'h00); // R2
  AST_SAME_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (cmd_wbyte[CMD_START_BIT] == cmd_q[CMD_START_BIT]) && !eng_done)
      |=> (!start_q && !cancel_q && active_q == $past(active_q))); // R3
endmodule

// File: rtl/bmr_ptr_regs.sv
module bmr_ptr_regs #(
  parameter int PTR_W      = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_we,
  input  logic [PTR_W/8-1:0] base_be,
  input  logic [PTR_W-1:0]   base_wdata,
  input  logic               reload,
  input  logic               advance,
  output logic [PTR_W-1:0]   base_q,
  output logic [PTR_W-1:0]   cur_q
);
  localparam int LANES = PTR_W / 8;

  function automatic logic [PTR_W-1:0] next_desc(input logic [PTR_W-1:0] p);
    return p + PTR_W'(DESC_BYTES);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[8*i +: 8] <= '0;
      end else if (base_we && base_be[i]) begin
        if (i == 0) base_q[8*i +: 8] <= base_wdata[8*i +: 8] & 8'hFC;
        else        base_q[8*i +: 8] <= base_wdata[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '0;
    else if (reload)  cur_q <= base_q;
    else if (advance) cur_q <= next_desc(cur_q);
  end

  AST_RELOAD_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cur_q == $past(base_q)); // R4
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> base_q[1:0] == 2'b00); // R6
  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reload) |=> cur_q == $past(cur_q) + PTR_W'(DESC_BYTES)); // R10
endmodule

// File: rtl/bmr_irq_stat.sv
module bmr_irq_stat
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_irq,
  input  logic       eng_err,
  input  logic       stat_we,
  input  logic [7:0] stat_wbyte,
  output logic       irq_out,
  output logic       int_q,
  output logic       err_q
);
  logic drv_q, irq_rise, clr_int, clr_err;

  always_comb begin
    irq_out  = drv_irq;
    irq_rise = drv_irq & ~drv_q;
    clr_int  = stat_we & stat_wbyte[ST_INT_BIT];
    clr_err  = stat_we & stat_wbyte[ST_ERR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      int_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      drv_q <= drv_irq;
      int_q <= irq_rise | (int_q & ~clr_int);
      err_q <= eng_err  | (err_q & ~clr_err);
    end
  end

  AST_INT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> int_q); // R7
  AST_INT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_int && !irq_rise) |=> !int_q); // R8
  AST_ERR_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err_q); // R10
endmodule

// File: rtl/busmaster_dma_regs.sv
module busmaster_dma_regs
  import bmr_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [3:0]         reg_be,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               drv_irq,
  output logic               irq_out,
  output logic               eng_start,
  output logic               eng_cancel,
  input  logic               eng_done,
  input  logic               eng_more,
  input  logic               eng_next,
  input  logic               eng_err,
  output logic               eng_dir,
  output logic [PTR_W-1:0]   cur_desc_ptr
);
  logic       cmd_we, stat_we, base_we, reload, active_q, int_q, err_q;
  logic [7:0] cmd_q;
  logic [PTR_W-1:0] base_q;
  stat_t      st;

  always_comb begin
    cmd_we  = reg_we & ~reg_sel & reg_be[CMD_BYTE];
    stat_we = reg_we & ~reg_sel & reg_be[STAT_BYTE];
    base_we = reg_we &  reg_sel;
    st      = '{irq: int_q, err: err_q, act: active_q};
    if (reg_sel) reg_rdata = base_q;
    else         reg_rdata = {8'h00, stat_byte(st), 8'h00, cmd_q};
    eng_dir = cmd_q[CMD_DIR_BIT];
  end

  bmr_cmd_ctrl u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wbyte(reg_wdata[7:0]),
    .eng_done(eng_done), .eng_more(eng_more), .cmd_q(cmd_q),
    .active_q(active_q), .start_q(eng_start), .cancel_q(eng_cancel),
    .reload(reload)
  );

  bmr_ptr_regs #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_be(reg_be),
    .base_wdata(reg_wdata), .reload(reload), .advance(eng_next),
    .base_q(base_q), .cur_q(cur_desc_ptr)
  );

  bmr_irq_stat u_irq (
    .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .eng_err(eng_err),
    .stat_we(stat_we), .stat_wbyte(reg_wdata[23:16]), .irq_out(irq_out),
    .int_q(int_q), .err_q(err_q)
  );

  AST_DIR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> eng_dir == $past(reg_wdata[CMD_DIR_BIT])); // R11
endmodule

// File: tb/busmaster_dma_regs_bench.sv
module busmaster_dma_regs_bench;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_we = 0, drv_irq = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, cur_desc_ptr;
  logic irq_out, eng_start, eng_cancel, eng_dir;
  logic eng_done = 0, eng_more = 0, eng_next = 0, eng_err = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_cmd = 0;
  logic m_act = 0, m_err = 0, m_int = 0, m_start = 0, m_cancel = 1, m_drvq = 0;
  logic [31:0] m_base = 0, m_cur = 0;

  always #5 clk = ~clk;

  busmaster_dma_regs u_busmaster_dma_regs (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m = 0;
    for (int i = 0; i < 4; i++) if (be[i]) m |= 32'hFF << (8 * i);
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(input logic sel);
    if (sel) return m_base;
    return {8'h00, 5'b0, m_int, m_err, m_act, 8'h00, m_cmd};
  endfunction

  task automatic model_upd();
    logic cw, sw, rise, na, ns, nc;
    logic [31:0] ncur, mk;
    cw = reg_we && !reg_sel && reg_be[0];
    sw = reg_we && !reg_sel && reg_be[2];
    rise = drv_irq && !m_drvq;
    na = m_act; ns = 0; nc = 0; ncur = m_cur;
    if (eng_done) na = eng_more;
    if (eng_next) ncur = m_cur + 32'd8;
    if (cw && reg_wdata[0] && !m_cmd[0]) begin
      ncur = m_base;
      if (!m_act) begin na = 1; ns = 1; end
    end else if (cw && !reg_wdata[0] && m_cmd[0]) begin
      na = 0; nc = 1;
    end
    m_int = rise || (m_int && !(sw && reg_wdata[18]));
    m_err = eng_err || (m_err && !(sw && reg_wdata[17]));
    if (cw) m_cmd = {4'b0, reg_wdata[3], 2'b0, reg_wdata[0]};
    if (reg_we && reg_sel) begin
      mk = lane_mask(reg_be);
      m_base = ((m_base & ~mk) | (reg_wdata & mk)) & 32'hFFFF_FFFC;
    end
    m_act = na; m_start = ns; m_cancel = nc; m_cur = ncur; m_drvq = drv_irq;
  endtask

  task automatic compare();
    chk(eng_start === m_start, "R4 eng_start", 32'(eng_start), 32'(m_start));
    chk(eng_cancel === m_cancel, "R5 eng_cancel", 32'(eng_cancel), 32'(m_cancel));
    chk(reg_rdata === exp_rd(reg_sel), reg_sel ? "R6 rdata" : "R2 rdata", reg_rdata, exp_rd(reg_sel));
    chk(cur_desc_ptr === m_cur, "R10 cur_desc_ptr", cur_desc_ptr, m_cur);
    chk(irq_out === drv_irq, "R7 irq_out", 32'(irq_out), 32'(drv_irq));
    chk(eng_dir === m_cmd[3], "R11 eng_dir", 32'(eng_dir), 32'(m_cmd[3]));
  endtask

  task automatic go(input logic sel, input logic we, input logic [3:0] be, input logic [31:0] wd,
                    input logic drv, input logic dn, input logic mo, input logic nx, input logic er);
    reg_sel = sel; reg_we = we; reg_be = be; reg_wdata = wd; drv_irq = drv;
    eng_done = dn; eng_more = mo; eng_next = nx; eng_err = er;
    @(posedge clk);
    model_upd();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input logic sel, input logic drv);
    go(sel, 0, 4'h0, 32'h0, drv, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(eng_cancel === 1'b1, "R1 cancel in reset", 32'(eng_cancel), 1);
    chk(reg_rdata === 32'h0, "R1 dword0 in reset", reg_rdata, 0);
    reg_sel = 1; #1;
    chk(reg_rdata === 32'h0 && cur_desc_ptr === 32'h0, "R1 pointers in reset", reg_rdata | cur_desc_ptr, 0);
    reg_sel = 0;
    rst_n = 1;
    idle(0, 0);
    // R6: full and partial pointer writes, low bits forced to zero
    go(1, 1, 4'hF, 32'h1234_5677, 0, 0, 0, 0, 0);
    chk(reg_rdata === 32'h1234_5674, "R6 aligned", reg_rdata, 32'h1234_5674);
    go(1, 1, 4'b0100, 32'h55AB_9999, 0, 0, 0, 0, 0);
    chk(reg_rdata === 32'h12AB_5674, "R6 byte lane", reg_rdata, 32'h12AB_5674);
    // R2/R4: start with all bits set
    go(0, 1, 4'h1, 32'h0000_00FF, 0, 0, 0, 0, 0);
    chk(reg_rdata[7:0] === 8'h09, "R2 cmd mask", reg_rdata, 32'h09);
    chk(eng_start === 1 && reg_rdata[16] === 1, "R4 start+active", {eng_start, reg_rdata[16]}, 2'b11);
    chk(cur_desc_ptr === 32'h12AB_5674, "R4 reload", cur_desc_ptr, 32'h12AB_5674);
    idle(0, 0);
    chk(eng_start === 0, "R4 one-cycle start", 32'(eng_start), 0);
    // R3: rewrite same start value
    go(0, 1, 4'h1, 32'h0000_0001, 0, 0, 0, 0, 0);
    chk(eng_start === 0 && eng_cancel === 0 && reg_rdata[16] === 1, "R3 quiet rewrite",
        {eng_start, eng_cancel, reg_rdata[16]}, 3'b001);
    // R10: descriptor advance
    go(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk(cur_desc_ptr === 32'h12AB_567C, "R10 advance", cur_desc_ptr, 32'h12AB_567C);
    // R8: active not writable
    go(0, 1, 4'h4, 32'h0007_0000, 0, 0, 0, 0, 0);
    chk(reg_rdata[16] === 1, "R8 active read-only", 32'(reg_rdata[16]), 1);
    // R9: engine end with and without more
    go(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk(reg_rdata[16] === 1, "R9 end more=1", 32'(reg_rdata[16]), 1);
    go(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk(reg_rdata[16] === 0, "R9 end more=0", 32'(reg_rdata[16]), 0);
    // R5: stop
    go(0, 1, 4'h1, 32'h0000_0008, 0, 0, 0, 0, 0);
    chk(eng_cancel === 1 && reg_rdata[16] === 0, "R5 cancel", {eng_cancel, reg_rdata[16]}, 2'b10);
    idle(0, 0);
    chk(eng_cancel === 0, "R5 one-cycle cancel", 32'(eng_cancel), 0);
    // R4: start rise while still active gives no start pulse but reloads
    go(0, 0, 0, 0, 0, 1, 1, 0, 0);
    go(0, 0, 0, 0, 0, 0, 0, 1, 0);
    go(0, 1, 4'h1, 32'h0000_0001, 0, 0, 0, 0, 0);
    chk(eng_start === 0 && cur_desc_ptr === 32'h12AB_5674, "R4 active already",
        {eng_start, cur_desc_ptr}, {1'b0, 32'h12AB_5674});
    // R7/R8: interrupt latch and clear
    go(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk(reg_rdata[18] === 1 && irq_out === 1, "R7 int set", {reg_rdata[18], irq_out}, 2'b11);
    go(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(reg_rdata[18] === 1 && irq_out === 0, "R7 int held on fall", {reg_rdata[18], irq_out}, 2'b10);
    go(0, 1, 4'h4, 32'h0004_0000, 0, 0, 0, 0, 0);
    chk(reg_rdata[18] === 0, "R8 int cleared", 32'(reg_rdata[18]), 0);
    // R10/R8: error latch and clear
    go(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(reg_rdata[17] === 1, "R10 err set", 32'(reg_rdata[17]), 1);
    go(0, 1, 4'h4, 32'h0002_0000, 0, 0, 0, 0, 0);
    chk(reg_rdata[17] === 0, "R8 err cleared", 32'(reg_rdata[17]), 0);
    // random phase, every output compared against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      go(r[0], (r[3:1] == 0), r[7:4], $urandom, r[8] ^ (r[12:9] == 0) ? ~drv_irq : drv_irq,
         r[15:13] == 0, r[16], r[19:17] == 0, r[23:20] == 0);
      go(r[24], 0, 4'h0, 32'h0, drv_irq, 0, 0, 0, 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule